// File: doc/BRIEF.md
# Packed Register-Write Command Decoder

This block sits behind a command-stream fetch engine and turns a stream of 32-bit words into single register writes on a simple valid/ready register bus. The stream is cut into fixed packets of five words. The first word of a packet is a header that holds four 8-bit compact register indices. The four words after it are the data values for those indices.

Each index is expanded into a full, word-aligned byte address. The top bit of the index chooses one of two register windows, and the remaining seven bits give the word offset inside that window. The writes leave the block one at a time, in header byte order. The downstream register file may stall any of them.

The block raises a single-cycle pulse when a write whose address carries the batch-finish offset bit is taken. It also shows when no packet is in progress and no write is waiting.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: A packet is one header word followed by four data words, and it produces exactly four register writes. The write for the first data word uses header bits 7:0, the second uses bits 15:8, the third bits 23:16 and the fourth bits 31:24, and the writes leave in that order.
- R2: An index with bit 7 clear expands to byte address 0x1C00 + index*4. Index 0x00 gives 0x1C00 and index 0x7F gives 0x1DFC.
- R3: An index with bit 7 set expands to byte address 0x2C00 + (index & 0x7F)*4. Index 0x80 gives 0x2C00 and index 0xFF gives 0x2DFC.
- R4: Every issued address has its two low bits at zero.
- R5: `batch_end` is high for exactly the cycles in which a write with address bit 8 (offset 0x0100) set is accepted (`wr_valid` and `wr_ready` both high). It is low in every other cycle. This bit is set for indices whose bit 6 is set.
- R6: A write to the pad register (index 0x15, address 0x1C54) is issued like any other write and is never dropped.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R8: `in_ready` is low while a register write is pending. A header or data word is accepted only when no write is pending.
- R9: `idle` is high only when the decoder is waiting for a header and no write is pending. It is low between a header and the last write of its packet.
- R10: A synchronous `rst` returns the decoder to header wait, drops any partial packet and any pending write, and leaves `idle` high and `wr_valid` low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word accepted this cycle when high with `in_valid` |
| in_data | input | 32 | Command word (header or data) |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Register file takes the write this cycle |
| wr_addr | output | 16 | Expanded byte address |
| wr_data | output | 32 | Write data |
| batch_end | output | 1 | Pulse: a batch-finishing write is being taken |
| idle | output | 1 | No packet in progress and no write pending |

## Verification
The assertions assume that the source keeps `in_data` stable while `in_valid` is high and unaccepted, and that it always sends whole five-word packets. They also assume that the register file drives `wr_ready` freely, whether or not a write is pending. The stimulus holds each word until it is accepted and sends complete packets, except in one reset case where a partial packet is cut off on purpose. Random stall rates on `wr_ready` cover long holds as well as back-to-back acceptance.

// File: rtl/pkd_pkg.sv
package pkd_pkg;
   typedef enum logic {
      ST_HDR  = 1'b0,
      ST_DATA = 1'b1
   } pkd_state_e;
endpackage

// File: rtl/pkd_index_expand.sv
module pkd_index_expand #(
   parameter int          IDX_W     = 8,
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] WIN0_BASE = 16'h1C00,
   parameter logic [15:0] WIN1_BASE = 16'h2C00
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int OFF_W = IDX_W - 1;

   if (ADDR_W < OFF_W + 3) begin : g_bad_width
      $error("pkd_index_expand: ADDR_W too small for IDX_W");
   end

   logic [OFF_W-1:0]  off;
   logic [ADDR_W-1:0] base;

   always_comb begin
      off  = idx[OFF_W-1:0];
      base = idx[IDX_W-1] ? ADDR_W'(WIN1_BASE) : ADDR_W'(WIN0_BASE);
      addr = base + ADDR_W'({off, 2'b00});
   end
endmodule

// File: rtl/pkd_seq.sv
module pkd_seq
   import pkd_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [DATA_W-1:0]         in_data,
   input  logic                      wr_busy,
   output logic                      in_ready,
   output logic                      load,
   output logic [DATA_W-1:0]         hdr_q,
   output logic [$clog2(SLOTS)-1:0]  slot_q,
   output logic                      idle
);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

   if (SLOTS < 2) begin : g_bad_slots
      $error("pkd_seq: SLOTS must be at least 2");
   end

   pkd_state_e state_q;
   logic       take;

   always_comb begin
      in_ready = !wr_busy;
      take     = in_valid && in_ready;
      load     = take && (state_q == ST_DATA);
      idle     = (state_q == ST_HDR) && !wr_busy;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_HDR;
         slot_q  <= '0;
         hdr_q   <= '0;
      end else if (take) begin
         if (state_q == ST_HDR) begin
            hdr_q   <= in_data;
            slot_q  <= '0;
            state_q <= ST_DATA;
         end else begin
            slot_q <= slot_q + 1'b1;
            if (slot_q == LAST) begin
               state_q <= ST_HDR;
            end
         end
      end
   end
endmodule

// File: rtl/pkd_wr_port.sv
module pkd_wr_port #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              wr_ready,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else if (load) begin
         wr_valid <= 1'b1;
         wr_addr  <= ld_addr;
         wr_data  <= ld_data;
      end else if (wr_ready) begin
         wr_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder #(
   parameter int          DATA_W    = 32,
   parameter int          IDX_W     = 8,
   parameter int          ADDR_W    = 16,
   parameter int          EXEC_BIT  = 8,
   parameter logic [15:0] WIN0_BASE = 16'h1C00,
   parameter logic [15:0] WIN1_BASE = 16'h2C00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              batch_end,
   output logic              idle
);
   localparam int SLOTS  = DATA_W / IDX_W;
   localparam int SLOT_W = $clog2(SLOTS);

   if (SLOTS * IDX_W != DATA_W) begin : g_bad_pack
      $error("cmd_pkt_decoder: header must hold a whole number of indices");
   end
   if (EXEC_BIT >= ADDR_W) begin : g_bad_exec
      $error("cmd_pkt_decoder: EXEC_BIT outside the address");
   end

   logic              load;
   logic [DATA_W-1:0] hdr_q;
   logic [SLOT_W-1:0] slot_q;
   logic [ADDR_W-1:0] slot_addr [SLOTS];
   logic [ADDR_W-1:0] sel_addr;

   pkd_seq #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_data  (in_data),
      .wr_busy  (wr_valid),
      .in_ready (in_ready),
      .load     (load),
      .hdr_q    (hdr_q),
      .slot_q   (slot_q),
      .idle     (idle)
   );

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      pkd_index_expand #(
         .IDX_W(IDX_W), .ADDR_W(ADDR_W),
         .WIN0_BASE(WIN0_BASE), .WIN1_BASE(WIN1_BASE)
      ) u_expand (
         .idx  (hdr_q[s*IDX_W +: IDX_W]),
         .addr (slot_addr[s])
      );
   end

   assign sel_addr = slot_addr[slot_q];

   pkd_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .ld_addr  (sel_addr),
      .ld_data  (in_data),
      .wr_ready (wr_ready),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   assign batch_end = wr_valid && wr_ready && wr_addr[EXEC_BIT];
endmodule

// File: rtl/pkd_checker.sv
module pkd_checker #(
   parameter int          DATA_W    = 32,
   parameter int          IDX_W     = 8,
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] WIN0_BASE = 16'h1C00,
   parameter logic [15:0] WIN1_BASE = 16'h2C00
) (
   input logic              clk,
   input logic              rst,
   input logic              in_ready,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              batch_end,
   input logic              idle
);
   localparam int SPAN = (2 ** (IDX_W - 1)) * 4;
   localparam logic [ADDR_W:0] W0_LO = (ADDR_W+1)'(WIN0_BASE);
   localparam logic [ADDR_W:0] W1_LO = (ADDR_W+1)'(WIN1_BASE);
   localparam logic [ADDR_W:0] W0_HI = W0_LO + (ADDR_W+1)'(SPAN);
   localparam logic [ADDR_W:0] W1_HI = W1_LO + (ADDR_W+1)'(SPAN);

   logic [ADDR_W:0] a_ext;
   assign a_ext = {1'b0, wr_addr};

   // R7
   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   // R4
   a_r4_align: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> wr_addr[1:0] == 2'b00);

   // R2 and R3
   a_r3_window: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> ((a_ext >= W0_LO && a_ext < W0_HI) ||
                    (a_ext >= W1_LO && a_ext < W1_HI)));

   // R8
   a_r8_no_accept: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> !in_ready);

   // R9
   a_r9_idle: assert property (@(posedge clk) disable iff (rst)
      idle |-> !wr_valid);

   // R5
   a_r5_taken: assert property (@(posedge clk) disable iff (rst)
      batch_end |-> wr_valid && wr_ready);

   // R5
   a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
      batch_end |=> !batch_end);

   // R10
   a_r10_reset: assert property (@(posedge clk)
      rst |=> idle && !wr_valid);
endmodule

bind cmd_pkt_decoder pkd_checker #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
   .WIN0_BASE(WIN0_BASE), .WIN1_BASE(WIN1_BASE)
) u_pkd_checker (
   .clk       (clk),
   .rst       (rst),
   .in_ready  (in_ready),
   .wr_valid  (wr_valid),
   .wr_ready  (wr_ready),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .batch_end (batch_end),
   .idle      (idle)
);

// File: tb/cmd_pkt_decoder_bench.sv
module cmd_pkt_decoder_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        wr_valid;
   logic        wr_ready = 1'b0;
   logic [15:0] wr_addr;
   logic [31:0] wr_data;
   logic        batch_end;
   logic        idle;

   int checks = 0;
   int fails  = 0;
   int rdy_pct = 0;
   logic [15:0] exp_a [$];
   logic [31:0] exp_d [$];
   logic        hold_prev = 1'b0;
   logic [15:0] prev_a;
   logic [31:0] prev_d;

   always #5 clk = ~clk;

   cmd_pkt_decoder u_cmd_pkt_decoder (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .batch_end(batch_end), .idle(idle)
   );

   function automatic logic [15:0] ref_addr(input logic [7:0] ix);
      logic [15:0] base;
      base = ix[7] ? 16'h2C00 : 16'h1C00;
      return base + 16'(ix[6:0]) * 16'd4;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Downstream stall driver and write monitor
   always @(negedge clk) begin
      wr_ready = ($urandom_range(0, 99) < rdy_pct);
      #1;
      if (rst) begin
         hold_prev = 1'b0;
      end else begin
         if (hold_prev) begin
            chk(wr_valid && wr_addr == prev_a && wr_data == prev_d, "R7 hold",
                {wr_addr, 15'd0, wr_valid}, {prev_a, 16'd1});
         end
         if (wr_valid && wr_ready) begin
            if (exp_a.size() == 0) begin
               chk(1'b0, "R1 extra write", {16'd0, wr_addr}, 32'd0);
            end else begin
               logic [15:0] ea;
               logic [31:0] ed;
               ea = exp_a.pop_front();
               ed = exp_d.pop_front();
               chk(wr_addr == ea, "R1/R2/R3/R4 addr", {16'd0, wr_addr}, {16'd0, ea});
               chk(wr_data == ed, "R1/R6 data", wr_data, ed);
               chk(batch_end == ea[8], "R5 batch_end", {31'd0, batch_end}, {31'd0, ea[8]});
            end
         end else if (batch_end) begin
            chk(1'b0, "R5 stray pulse", 32'd1, 32'd0);
         end
         hold_prev = wr_valid && !wr_ready;
         prev_a = wr_addr;
         prev_d = wr_data;
      end
   end

   task automatic send_word(input logic [31:0] w);
      in_data  = w;
      in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_pkt(input logic [31:0] h, input logic [31:0] d0,
                           input logic [31:0] d1, input logic [31:0] d2,
                           input logic [31:0] d3);
      logic [31:0] dv [4];
      dv = '{d0, d1, d2, d3};
      for (int k = 0; k < 4; k++) begin
         exp_a.push_back(ref_addr(h[k*8 +: 8]));
         exp_d.push_back(dv[k]);
      end
      send_word(h);
      for (int k = 0; k < 4; k++) send_word(dv[k]);
   endtask

   task automatic drain();
      while (exp_a.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      #2;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240601));
      repeat (3) @(negedge clk);
      #2;
      chk(idle && !wr_valid, "R10 reset state", {30'd0, idle, wr_valid}, 32'd2);
      rst = 1'b0;
      rdy_pct = 60;
      @(negedge clk);

      // R2 R3 window edges: indices 00, 7F, 80, FF
      send_pkt(32'hFF807F00, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
      drain();
      chk(idle, "R9 idle after packet", {31'd0, idle}, 32'd1);

      // R6 pad slots
      send_pkt(32'h15151515, 32'hA0A0A0A0, 32'hA1A1A1A1, 32'hA2A2A2A2, 32'hA3A3A3A3);
      drain();

      // R9 idle low mid packet
      exp_a.push_back(ref_addr(8'h40)); exp_d.push_back(32'hC0);
      exp_a.push_back(ref_addr(8'hC1)); exp_d.push_back(32'hC1);
      exp_a.push_back(ref_addr(8'h3F)); exp_d.push_back(32'hC2);
      exp_a.push_back(ref_addr(8'hBF)); exp_d.push_back(32'hC3);
      send_word(32'hBF3FC140);
      #1;
      chk(!idle, "R9 idle low after header", {31'd0, idle}, 32'd0);
      for (int k = 0; k < 4; k++) send_word(32'hC0 + 32'(k));
      drain();

      // R8 and R10: stalled partial packet then reset
      rdy_pct = 0;
      @(negedge clk);
      send_word(32'h7F7F7F7F);
      send_word(32'hDEADBEEF);
      #1;
      chk(!in_ready && wr_valid, "R8 in_ready low while pending",
          {30'd0, in_ready, wr_valid}, 32'd1);
      chk(!idle, "R9 idle low while pending", {31'd0, idle}, 32'd0);
      @(negedge clk);
      rst = 1'b1;
      exp_a.delete();
      exp_d.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #2;
      chk(idle && !wr_valid, "R10 reset drops partial", {30'd0, idle, wr_valid}, 32'd2);
      rdy_pct = 70;
      send_pkt(32'h0180027F, 32'h5, 32'h6, 32'h7, 32'h8);
      drain();

      // Random packets with varying stall rates
      for (int p = 0; p < 300; p++) begin
         rdy_pct = (p % 3 == 0) ? 20 : ((p % 3 == 1) ? 100 : 55);
         send_pkt($urandom(), $urandom(), $urandom(), $urandom(), $urandom());
      end
      drain();
      chk(idle && exp_a.size() == 0, "R1 all writes seen", {31'd0, idle}, 32'd1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule